// File: doc/BRIEF.md
# TMDS Three-Lane Symbol Decoder

This block takes the three 10-bit symbols of one pixel, already aligned to each other and to word boundaries, and turns them into a registered video word. Each symbol is either one of four fixed control tokens, which carry two control bits, or a transition-coded data symbol, which carries one 8-bit colour sample. Lane 0 is blue, lane 1 is green and lane 2 is red.

A pixel is active only when none of the three lanes holds a token. The decoder then drives the three recovered colour bytes with the data-enable high. When a token is present the colour outputs are forced to zero. The blue lane's token drives the two sync outputs, and the green and red tokens drive two spare 2-bit control outputs. If some lanes hold tokens and others hold data in the same pixel, the lanes are not in agreement, and the block raises an error flag for that pixel.

Top module: `tmds_rx_decoder`

## Requirements
- R1: While rst_n is low at a clock edge, every output is zero after that edge.
- R2: A symbol is a control token exactly when it equals one of four codes, with the control pair shown as {c1,c0}: 10'b1101010100 is 00, 10'b0010101011 is 01, 10'b0101010100 is 10, 10'b1010101011 is 11.
- R3: A token on the blue lane sets hsync_o to c0 and vsync_o to c1.
- R4: A token on the green lane sets ctl_g_o to {c1,c0}, and a token on the red lane sets ctl_r_o to {c1,c0}.
- R5: de_o is 1 exactly when none of the three lanes holds a token.
- R6: For a data symbol s, q = s[9] ? ~s[7:0] : s[7:0]. The pixel is d[0] = q[0], and for i from 1 to 7, d[i] = q[i] ^ q[i-1] when s[8] is 1 and ~(q[i] ^ q[i-1]) when s[8] is 0.
- R7: When de_o is 0, red_o, green_o and blue_o are all zero.
- R8: hsync_o and vsync_o, ctl_g_o and ctl_r_o each keep their value when their own lane holds no token.
- R9: sym_err_o is 1 exactly when at least one lane, but not all three, holds a token.
- R10: Every output reflects the symbols sampled at the previous rising clock edge, a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_b_i | input | 10 | Blue lane symbol (lane 0) |
| sym_g_i | input | 10 | Green lane symbol (lane 1) |
| sym_r_i | input | 10 | Red lane symbol (lane 2) |
| red_o | output | 8 | Decoded red sample |
| green_o | output | 8 | Decoded green sample |
| blue_o | output | 8 | Decoded blue sample |
| hsync_o | output | 1 | Horizontal sync from blue c0 |
| vsync_o | output | 1 | Vertical sync from blue c1 |
| de_o | output | 1 | Active-pixel flag |
| ctl_g_o | output | 2 | Control pair from green lane |
| ctl_r_o | output | 2 | Control pair from red lane |
| sym_err_o | output | 1 | Lanes disagree on token versus data |

## Verification
There is only one register stage between the symbols and the ports, so a fault in the token match or in the chained XOR/XNOR recovery shows up one cycle later on the pixel bytes, on de_o or on the error flag. A held control value that is overwritten or lost shows only when the next pixel without a token arrives, so the bench sends mixed and data cycles right after each blanking pattern. All four combinations of inversion and coding mode are driven on every lane, so a bit-order or polarity slip in one path cannot be masked by another.

// File: rtl/tmds_dec_pkg.sv
// Shared widths and control-token codes for the TMDS symbol decoder.
// Assumes 10-bit symbols carrying 8-bit samples or 2-bit control pairs.
package tmds_dec_pkg;
    localparam int SYM_W  = 10;
    localparam int PIX_W  = 8;
    localparam int CTL_W  = 2;
    localparam int LANES  = 3;

    localparam logic [SYM_W-1:0] TOK_00 = 10'b1101010100;
    localparam logic [SYM_W-1:0] TOK_01 = 10'b0010101011;
    localparam logic [SYM_W-1:0] TOK_10 = 10'b0101010100;
    localparam logic [SYM_W-1:0] TOK_11 = 10'b1010101011;
endpackage

// File: rtl/tmds_lane_decode.sv
// Combinational decode of one lane's symbol.
// Detects the four control tokens and, in parallel, recovers the
// transition-coded 8-bit sample. Assumes the symbol is word-aligned.
module tmds_lane_decode
    import tmds_dec_pkg::*;
#(
    parameter int SW = SYM_W,
    parameter int PW = PIX_W
) (
    input  logic [SW-1:0] sym_i,
    output logic          is_tok_o,
    output logic [CTL_W-1:0] ctl_o,
    output logic [PW-1:0] pix_o
);
    localparam int INV_BIT = SW - 1;
    localparam int XOR_BIT = SW - 2;

    logic [PW-1:0] q_w;

    // Match the symbol against the four control tokens.
    always_comb begin
        is_tok_o = 1'b1;
        ctl_o    = '0;
        case (sym_i)
            TOK_00:  ctl_o = 2'b00;
            TOK_01:  ctl_o = 2'b01;
            TOK_10:  ctl_o = 2'b10;
            TOK_11:  ctl_o = 2'b11;
            default: is_tok_o = 1'b0;
        endcase
    end

    // Undo the optional inversion of the low payload bits.
    always_comb begin
        q_w = sym_i[INV_BIT] ? ~sym_i[PW-1:0] : sym_i[PW-1:0];
    end

    // Undo the XOR or XNOR chain between neighbouring bits.
    always_comb begin
        pix_o[0] = q_w[0];
        for (int i = 1; i < PW; i++) begin
            pix_o[i] = sym_i[XOR_BIT] ? (q_w[i] ^ q_w[i-1])
                                      : ~(q_w[i] ^ q_w[i-1]);
        end
    end
endmodule

// File: rtl/tmds_out_stage.sv
// Output register stage that merges the per-lane decode results.
// Pixels pass only when no lane holds a token; each lane's control
// pair is held until that lane carries a new token. Reset is
// synchronous and active low.
module tmds_out_stage
    import tmds_dec_pkg::*;
#(
    parameter int NL = LANES,
    parameter int PW = PIX_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NL-1:0]               is_tok_i,
    input  logic [NL-1:0][CTL_W-1:0]    ctl_i,
    input  logic [NL-1:0][PW-1:0]       pix_i,
    output logic [NL-1:0][CTL_W-1:0]    ctl_q,
    output logic [NL-1:0][PW-1:0]       pix_q,
    output logic                        de_q,
    output logic                        err_q
);
    logic any_tok_w;
    logic all_tok_w;

    // Summarise token presence across the lanes.
    always_comb begin
        any_tok_w = |is_tok_i;
        all_tok_w = &is_tok_i;
    end

    // Register data enable and the lane-disagreement flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            de_q  <= !any_tok_w;
            err_q <= any_tok_w && !all_tok_w;
        end
    end

    for (genvar g = 0; g < NL; g++) begin : g_lane
        // Register the lane's sample, zeroed outside active pixels.
        always_ff @(posedge clk) begin
            if (!rst_n)          pix_q[g] <= '0;
            else if (any_tok_w)  pix_q[g] <= '0;
            else                 pix_q[g] <= pix_i[g];
        end

        // Capture the lane's control pair only on a token.
        always_ff @(posedge clk) begin
            if (!rst_n)           ctl_q[g] <= '0;
            else if (is_tok_i[g]) ctl_q[g] <= ctl_i[g];
        end

        // R8
        ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!is_tok_i[g] && rst_n) |=> $stable(ctl_q[g]));

        // R3
        ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (is_tok_i[g] && rst_n) |=> (ctl_q[g] == $past(ctl_i[g])));
    end

    // R5
    de_follows_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_tok_i == '0 && rst_n) |=> de_q);

    // R7
    blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !de_q |-> (pix_q == '0));

    // R9
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !de_q);

    // R9
    err_mixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(is_tok_i) == 1 && rst_n) |=> err_q);
endmodule

// File: rtl/tmds_rx_decoder.sv
// Top of the three-lane TMDS symbol decoder.
// Lane 0 is blue, lane 1 green, lane 2 red. Assumes the symbols are
// already deskewed and word-aligned; output latency is one cycle.
module tmds_rx_decoder
    import tmds_dec_pkg::*;
#(
    parameter int SW = SYM_W,
    parameter int PW = PIX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sym_b_i,
    input  logic [SW-1:0] sym_g_i,
    input  logic [SW-1:0] sym_r_i,
    output logic [PW-1:0] red_o,
    output logic [PW-1:0] green_o,
    output logic [PW-1:0] blue_o,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic [CTL_W-1:0] ctl_g_o,
    output logic [CTL_W-1:0] ctl_r_o,
    output logic          sym_err_o
);
    localparam int NL = LANES;

    logic [NL-1:0][SW-1:0]    sym_w;
    logic [NL-1:0]            is_tok_w;
    logic [NL-1:0][CTL_W-1:0] ctl_w;
    logic [NL-1:0][PW-1:0]    pix_w;
    logic [NL-1:0][CTL_W-1:0] ctl_q;
    logic [NL-1:0][PW-1:0]    pix_q;

    // Gather the lane inputs into one indexed bundle.
    always_comb begin
        sym_w[0] = sym_b_i;
        sym_w[1] = sym_g_i;
        sym_w[2] = sym_r_i;
    end

    for (genvar g = 0; g < NL; g++) begin : g_dec
        tmds_lane_decode #(.SW(SW), .PW(PW)) lane_i (
            .sym_i    (sym_w[g]),
            .is_tok_o (is_tok_w[g]),
            .ctl_o    (ctl_w[g]),
            .pix_o    (pix_w[g])
        );
    end

    tmds_out_stage #(.NL(NL), .PW(PW)) out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_tok_i (is_tok_w),
        .ctl_i    (ctl_w),
        .pix_i    (pix_w),
        .ctl_q    (ctl_q),
        .pix_q    (pix_q),
        .de_q     (de_o),
        .err_q    (sym_err_o)
    );

    // Map the registered lane results onto named ports.
    always_comb begin
        blue_o  = pix_q[0];
        green_o = pix_q[1];
        red_o   = pix_q[2];
        hsync_o = ctl_q[0][0];
        vsync_o = ctl_q[0][1];
        ctl_g_o = ctl_q[1];
        ctl_r_o = ctl_q[2];
    end

    // R10
    de_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && $past(is_tok_w == '0)) |-> de_o);
endmodule

// File: tb/tmds_rx_decoder_tb.sv
// Scoreboard bench: the driver encodes stimulus and queues expected
// outputs; the monitor compares one cycle later.
module tmds_rx_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] r, g, b;
        logic       hs, vs, de, err;
        logic [1:0] cg, cr;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] sym_b, sym_g, sym_r;
    logic [7:0] red, green, blue;
    logic       hs, vs, de, err;
    logic [1:0] cg, cr;

    int   checks = 0;
    int   errors = 0;
    exp_t exp_q[$];

    // Model state for held control pairs.
    logic       m_hs = 0, m_vs = 0;
    logic [1:0] m_cg = 0, m_cr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmds_rx_decoder dut_i (
        .clk(clk), .rst_n(rst_n),
        .sym_b_i(sym_b), .sym_g_i(sym_g), .sym_r_i(sym_r),
        .red_o(red), .green_o(green), .blue_o(blue),
        .hsync_o(hs), .vsync_o(vs), .de_o(de),
        .ctl_g_o(cg), .ctl_r_o(cr), .sym_err_o(err)
    );

    function automatic logic [9:0] tok(input logic [1:0] c);
        case (c)
            2'b00:   return 10'b1101010100;
            2'b01:   return 10'b0010101011;
            2'b10:   return 10'b0101010100;
            default: return 10'b1010101011;
        endcase
    endfunction

    function automatic logic is_tok(input logic [9:0] s);
        return (s == tok(2'b00)) || (s == tok(2'b01)) ||
               (s == tok(2'b10)) || (s == tok(2'b11));
    endfunction

    // Encoder built from R6: forward transition chain then inversion.
    function automatic logic [9:0] enc(input logic [7:0] d, input logic inv,
                                       input logic xr);
        logic [7:0] q;
        q[0] = d[0];
        for (int i = 1; i < 8; i++)
            q[i] = xr ? (q[i-1] ^ d[i]) : ~(q[i-1] ^ d[i]);
        return {inv, xr, inv ? ~q : q};
    endfunction

    // Drive one pixel: tk = token mask, cv = control pairs, px = samples,
    // md = {inv,xr} per lane (lane 0 in low bits).
    task automatic drive(input logic [2:0] tk, input logic [5:0] cv,
                         input logic [23:0] px, input logic [5:0] md,
                         input string req);
        logic [9:0] s [3];
        logic [7:0] p [3];
        exp_t e;
        @(negedge clk);
        for (int l = 0; l < 3; l++) begin
            p[l] = px[l*8 +: 8];
            if (tk[l]) s[l] = tok(cv[l*2 +: 2]);
            else begin
                s[l] = enc(p[l], md[l*2+1], md[l*2]);
                while (is_tok(s[l])) begin
                    p[l] = p[l] + 8'd1;
                    s[l] = enc(p[l], md[l*2+1], md[l*2]);
                end
            end
        end
        sym_b = s[0]; sym_g = s[1]; sym_r = s[2];
        if (tk[0]) begin m_hs = cv[0]; m_vs = cv[1]; end
        if (tk[1]) m_cg = cv[3:2];
        if (tk[2]) m_cr = cv[5:4];
        e.de  = (tk == 3'b000);
        e.err = (tk != 3'b000) && (tk != 3'b111);
        e.b   = e.de ? p[0] : 8'h00;
        e.g   = e.de ? p[1] : 8'h00;
        e.r   = e.de ? p[2] : 8'h00;
        e.hs  = m_hs; e.vs = m_vs; e.cg = m_cg; e.cr = m_cr;
        e.req = req;
        if (rst_n) exp_q.push_back(e);
    endtask

    // Monitor: compare outputs one cycle after the symbols were driven.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if ({red, green, blue, hs, vs, de, err, cg, cr} !==
                    {e.r, e.g, e.b, e.hs, e.vs, e.de, e.err, e.cg, e.cr}) begin
                    errors++;
                    $display("FAIL %s: got r=%h g=%h b=%h hs=%b vs=%b de=%b err=%b cg=%b cr=%b exp r=%h g=%h b=%h hs=%b vs=%b de=%b err=%b cg=%b cr=%b",
                        e.req, red, green, blue, hs, vs, de, err, cg, cr,
                        e.r, e.g, e.b, e.hs, e.vs, e.de, e.err, e.cg, e.cr);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        sym_b = 10'h155; sym_g = 10'h2aa; sym_r = 10'h0f0;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs zero during reset
        checks++;
        if ({red, green, blue, hs, vs, de, err, cg, cr} !== '0) begin
            errors++;
            $display("FAIL R1: got %h exp 0", {red, green, blue, hs, vs, de, err, cg, cr});
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3: each blue token, other lanes blank with code 00
        for (int c = 0; c < 4; c++)
            drive(3'b111, {4'b0000, c[1:0]}, 24'h0, 6'h0, "R2_R3 blue token");
        // R4: green and red tokens
        for (int c = 0; c < 4; c++)
            drive(3'b111, {c[1:0], ~c[1:0], 2'b01}, 24'h0, 6'h0, "R4 green red tokens");
        // R5 R6 R10: active pixels under all inversion/coding modes
        for (int m = 0; m < 4; m++)
            for (int k = 0; k < 12; k++)
                drive(3'b000, 6'h0, $urandom, {3{m[1:0]}}, "R6 pixel decode");
        drive(3'b000, 6'h0, 24'h00ff80, 6'b100100, "R6 edge values");
        drive(3'b000, 6'h0, 24'h01fe7f, 6'b011011, "R6 edge values");
        // R8: tokens set state, then data cycle must not disturb it
        drive(3'b111, 6'b100111, 24'h0, 6'h0, "R8 set controls");
        drive(3'b000, 6'h0, 24'h123456, 6'b110001, "R8 hold over data");
        // R9 R7: mixed cycles with each single lane and each pair
        for (int t = 1; t < 7; t++) begin
            drive(t[2:0], 6'b011110, $urandom, 6'b101010, "R9_R7 mixed lanes");
            drive(3'b000, 6'h0, $urandom, 6'b000111, "R10 back to data");
        end
        // R5: alternate blanking and active
        for (int k = 0; k < 6; k++) begin
            drive(3'b111, {k[1:0], k[2:1], k[1:0]}, 24'h0, 6'h0, "R5 blank");
            drive(3'b000, 6'h0, $urandom, 6'b111000, "R5 active");
        end
        // R1: reset mid-stream clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        @(posedge clk);
        #1;
        checks++;
        if ({red, green, blue, hs, vs, de, err, cg, cr} !== '0) begin
            errors++;
            $display("FAIL R1: got %h exp 0", {red, green, blue, hs, vs, de, err, cg, cr});
        end
        repeat (3) @(posedge clk);
        #2;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule